// File: doc/BRIEF.md
# Shared Local Bus Ownership Arbiter

This block decides who drives a shared local bus. A processor is the default owner. Several other masters can ask for the bus, each by raising its own request line. When a request appears, the arbiter takes the bus away from the processor in one of two ways. The first is a polite hold handshake: the arbiter raises `hold_o`, and the processor finishes its current cycle and answers on `hlda_i`. The second is an immediate back-off: the arbiter pulls `boff_n_o` low, and the processor drops off the bus in the next clock.

Once the processor is off the bus, the arbiter hands the bus to the requesting masters one at a time. The lowest index has the highest priority. A master keeps the bus for as long as it holds its request or its lock. When no request is left, the arbiter gives the bus back to the processor.

A lock from the current owner freezes ownership. When the processor holds its lock, neither takeover starts. When a master holds its lock, no other master is granted. Every change of owner passes through one clock in which nobody owns the bus. No data moves through the block. All pins are plain level signals with no back-pressure, and the timing of the data cycles belongs to the masters.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after reset, `cpu_gnt_o`=1, `gnt_o`=0, `hold_o`=0 and `boff_n_o`=1.
- R2: While the processor owns the bus with `cpu_lock_i` low and `urgent_i` low, any request makes `hold_o` go high after the next clock edge. The processor keeps `cpu_gnt_o` and no master is granted until `hlda_i` is seen high.
- R3: In the hold path, the clock edge that samples `hlda_i` high starts one idle clock with no grant at all. The grant follows at the edge after that. While `hold_o` and a master grant are both high, `hlda_i` is high.
- R4: A grant always goes to the lowest-index request sampled on the edge that ends the idle clock. A master that requests later does not take the bus from a master that is already granted.
- R5: While the processor owns the bus with `cpu_lock_i` low and `urgent_i` high, a request makes `boff_n_o` go low after the next edge and removes `cpu_gnt_o`, without waiting for `hlda_i`. The master grant follows one clock later. `hold_o` and back-off are never active together.
- R6: While `cpu_lock_i` is high and the processor owns the bus, `cpu_gnt_o` stays high, `hold_o` does not leave the hold state toward a grant, and back-off never starts.
- R7: While a granted master holds `lock_i` of its own index high, its grant stays, even after it drops its request.
- R8: When the granted master has both its request and its lock low, its grant drops after the next edge. After one idle clock, the next pending master is granted.
- R9: If no request is pending at the end of an idle clock, `hold_o` and back-off are released. `cpu_gnt_o` returns only after an edge that samples `hlda_i` low.
- R10: At most one of `gnt_o` bits and `cpu_gnt_o` is high. A change of owner always passes through a cycle in which none is high.
- R11: `hold_o` stays high from the takeover until the return to the processor, including across the idle clocks between masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Bus request per master, index 0 highest priority |
| lock_i | input | NUM_MASTERS | Lock per master, honoured while that master owns the bus |
| urgent_i | input | 1 | Selects back-off instead of hold for the next takeover |
| cpu_lock_i | input | 1 | Processor lock, blocks any takeover |
| hlda_i | input | 1 | Hold acknowledge from the processor |
| gnt_o | output | NUM_MASTERS | One-hot grant to the masters |
| cpu_gnt_o | output | 1 | Processor owns the bus |
| hold_o | output | 1 | Hold request to the processor |
| boff_n_o | output | 1 | Back-off to the processor, active low |

## Verification
The assertions watch, on every cycle, the properties that hold whatever the stimulus:
- single ownership and the idle clock on every change of owner;
- hold and back-off never active together;
- no back-off while the processor is locked;
- a locked owner keeping the bus;
- the processor regaining the bus only after the acknowledge has fallen.

Only the bench's scenarios can show the exact cycle on which hold, back-off and each grant appear. The same holds for the choice of the lowest-index requester at each idle clock, for a master keeping the bus through its lock after dropping its request, and for the return sequence to the processor.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_CPU,   // processor owns the bus
    ST_HOLD,  // hold raised, waiting for acknowledge
    ST_GAP,   // idle clock, next owner chosen here
    ST_OWN,   // one master owns the bus
    ST_RET    // handing back, waiting for acknowledge to fall
  } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N    = 4,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/arb_onehot_dec.sv
module arb_onehot_dec #(
  parameter int N    = 4,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  output logic [N-1:0]    vec
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign vec[g] = en && (idx == IDXW'(g));
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] lock_i,
  input  logic                   urgent_i,
  input  logic                   cpu_lock_i,
  input  logic                   hlda_i,
  output logic [NUM_MASTERS-1:0] gnt_o,
  output logic                   cpu_gnt_o,
  output logic                   hold_o,
  output logic                   boff_n_o
);
  localparam int IDXW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  arb_state_e      state_q, state_d;
  logic [IDXW-1:0] owner_q, owner_d;
  logic            boff_path_q, boff_path_d;
  logic            pick_any;
  logic [IDXW-1:0] pick_idx;
  logic            taken;

  arb_prio_pick #(.N(NUM_MASTERS), .IDXW(IDXW)) u_pick (
    .req (req_i),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_comb begin
    state_d     = state_q;
    owner_d     = owner_q;
    boff_path_d = boff_path_q;
    case (state_q)
      ST_CPU: begin
        if (pick_any && !cpu_lock_i) begin
          state_d     = urgent_i ? ST_GAP : ST_HOLD;
          boff_path_d = urgent_i;
        end
      end
      ST_HOLD: begin
        if (hlda_i && !cpu_lock_i) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (pick_any) begin
          state_d = ST_OWN;
          owner_d = pick_idx;
        end else begin
          state_d = ST_RET;
        end
      end
      ST_OWN: begin
        if (!req_i[owner_q] && !lock_i[owner_q]) state_d = ST_GAP;
      end
      ST_RET: begin
        if (!hlda_i) begin
          state_d     = ST_CPU;
          boff_path_d = 1'b0;
        end
      end
      default: state_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_CPU;
      owner_q     <= '0;
      boff_path_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      owner_q     <= owner_d;
      boff_path_q <= boff_path_d;
    end
  end

  assign taken     = (state_q == ST_GAP) || (state_q == ST_OWN);
  assign cpu_gnt_o = (state_q == ST_CPU) || (state_q == ST_HOLD);
  assign hold_o    = !boff_path_q && (taken || state_q == ST_HOLD);
  assign boff_n_o  = !(boff_path_q && taken);

  arb_onehot_dec #(.N(NUM_MASTERS), .IDXW(IDXW)) u_dec (
    .en  (state_q == ST_OWN),
    .idx (owner_q),
    .vec (gnt_o)
  );
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int NUM_MASTERS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_MASTERS-1:0] req_i,
  input logic [NUM_MASTERS-1:0] lock_i,
  input logic                   cpu_lock_i,
  input logic                   hlda_i,
  input logic [NUM_MASTERS-1:0] gnt_o,
  input logic                   cpu_gnt_o,
  input logic                   hold_o,
  input logic                   boff_n_o
);
  logic [NUM_MASTERS:0] owners;
  assign owners = {gnt_o, cpu_gnt_o};

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owners)); // R10
  AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|owners) |=> ((owners == $past(owners)) || (owners == '0))); // R10
  AST_GNT_NEEDS_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && (|gnt_o)) |-> hlda_i); // R3
  AST_TAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> boff_n_o); // R5
  AST_BOFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boff_n_o) |-> !$past(cpu_lock_i)); // R6
  AST_CPU_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt_o && cpu_lock_i) |=> cpu_gnt_o); // R6
  AST_OWNER_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt_o & lock_i)) |=> (gnt_o == $past(gnt_o))); // R7
  AST_CPU_BACK_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_gnt_o) |-> !$past(hlda_i)); // R9
  AST_HOLD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(|req_i)); // R2
  AST_HOLD_UNTIL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> (gnt_o == '0)); // R11
endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .lock_i     (lock_i),
  .cpu_lock_i (cpu_lock_i),
  .hlda_i     (hlda_i),
  .gnt_o      (gnt_o),
  .cpu_gnt_o  (cpu_gnt_o),
  .hold_o     (hold_o),
  .boff_n_o   (boff_n_o)
);

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, lck = '0;
  logic         urgent = 1'b0, cpu_lock = 1'b0, hlda = 1'b0;
  logic [N-1:0] gnt;
  logic         cpu_gnt, hold, boff_n;
  int           checks = 0, fails = 0, lat = 2, cnt = 0;
  int           svc [N];

  always #10 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N)) u0 (
    .clk (clk), .rst_n (rst_n), .req_i (req), .lock_i (lck),
    .urgent_i (urgent), .cpu_lock_i (cpu_lock), .hlda_i (hlda),
    .gnt_o (gnt), .cpu_gnt_o (cpu_gnt), .hold_o (hold), .boff_n_o (boff_n)
  );

  // processor model: answers hold after lat extra clocks
  always begin
    @(posedge clk);
    #2;
    if (!rst_n) begin
      hlda = 1'b0; cnt = 0;
    end else if (hold !== hlda) begin
      if (cnt >= lat) begin hlda = hold; cnt = 0; end
      else cnt++;
    end else cnt = 0;
  end

  function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // from a hold just raised: no grant until acknowledge, idle clock, then grant
  task automatic await_grant(input logic [N-1:0] exp);
    int n = 0;
    while (!hlda && n < 30) begin tick(); chk("R2 no grant before hlda", 32'(gnt), 0); n++; end
    tick();
    chk("R3 idle clock grant", 32'(gnt), 0);
    chk("R3 idle clock cpu", 32'(cpu_gnt), 0);
    tick();
    chk("R3 grant after idle", 32'(gnt), 32'(exp));
  endtask

  // after the last request has been dropped at this negedge (hold path)
  task automatic await_return();
    int n = 0;
    tick();
    chk("R11 hold across idle", 32'(hold), 1);
    tick();
    chk("R9 hold released", 32'(hold), 0);
    chk("R9 cpu waits", 32'(cpu_gnt), 0);
    while (hlda && n < 30) begin tick(); chk("R9 cpu waits hlda", 32'(cpu_gnt), 0); n++; end
    tick();
    chk("R9 cpu back", 32'(cpu_gnt), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [N:0]   p_own;
    logic [N-1:0] p_req, p_gnt;
    logic         p_cpu, p_hlda;
    void'($urandom(32'd2024));
    foreach (svc[i]) svc[i] = 0;
    repeat (3) tick();
    chk("R1 reset cpu_gnt", 32'(cpu_gnt), 1);
    chk("R1 reset gnt", 32'(gnt), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset hold", 32'(hold), 0);
    chk("R1 after reset boff_n", 32'(boff_n), 1);
    chk("R1 after reset cpu_gnt", 32'(cpu_gnt), 1);

    // hold path, priority, no preemption, handover, lock
    req = 4'b0110;
    tick();
    chk("R2 hold raised", 32'(hold), 1);
    chk("R2 cpu keeps bus", 32'(cpu_gnt), 1);
    await_grant(4'b0010);
    req = 4'b0111;
    tick();
    chk("R4 no preemption", 32'(gnt), 32'b0010);
    req = 4'b0101;
    tick();
    chk("R8 grant dropped", 32'(gnt), 0);
    chk("R11 hold kept", 32'(hold), 1);
    tick();
    chk("R4 lowest pending wins", 32'(gnt), 32'b0001);
    lck = 4'b0001; req = 4'b0100;
    repeat (3) begin tick(); chk("R7 lock keeps grant", 32'(gnt), 32'b0001); end
    lck = '0;
    tick();
    chk("R8 release idle", 32'(gnt), 0);
    tick();
    chk("R8 next master", 32'(gnt), 32'b0100);
    req = '0;
    await_return();

    // back-off path
    urgent = 1'b1; req = 4'b1000;
    tick();
    chk("R5 boff low", 32'(boff_n), 0);
    chk("R5 no hold", 32'(hold), 0);
    chk("R5 cpu off", 32'(cpu_gnt), 0);
    tick();
    chk("R5 grant", 32'(gnt), 32'b1000);
    req = '0; urgent = 1'b0;
    tick();
    chk("R8 boff grant off", 32'(gnt), 0);
    tick();
    chk("R9 boff released", 32'(boff_n), 1);
    chk("R9 cpu not yet", 32'(cpu_gnt), 0);
    tick();
    chk("R9 cpu back boff", 32'(cpu_gnt), 1);

    // processor lock blocks both takeovers
    cpu_lock = 1'b1; urgent = 1'b1; req = 4'b0001;
    repeat (4) begin
      tick();
      chk("R6 cpu keeps", 32'(cpu_gnt), 1);
      chk("R6 no boff", 32'(boff_n), 1);
      chk("R6 no hold", 32'(hold), 0);
    end
    cpu_lock = 1'b0; urgent = 1'b0;
    tick();
    chk("R2 hold after unlock", 32'(hold), 1);
    await_grant(4'b0001);
    req = '0;
    await_return();

    // constrained random phase
    p_own = {gnt, cpu_gnt}; p_req = req; p_gnt = gnt; p_cpu = cpu_gnt; p_hlda = hlda;
    for (int c = 0; c < 4000; c++) begin
      tick();
      chk("R10 one owner", 32'($countones({gnt, cpu_gnt}) <= 1), 1);
      if (p_own != '0 && {gnt, cpu_gnt} != '0) chk("R10 gap on change", 32'({gnt, cpu_gnt}), 32'(p_own));
      if (gnt != '0 && p_gnt == '0) chk("R4 random priority", 32'(gnt), 32'(lowest(p_req)));
      if (cpu_gnt && !p_cpu) chk("R9 random hlda low", 32'(p_hlda), 0);
      if (!boff_n) chk("R5 random excl", 32'(hold), 0);
      for (int i = 0; i < N; i++) begin
        if (!req[i]) begin
          if ($urandom % 8 == 0) req[i] = 1'b1;
        end else if (gnt[i]) begin
          if (svc[i] == 0) begin
            svc[i] = 1 + int'($urandom % 5);
            lck[i] = ($urandom % 4 == 0);
          end else begin
            svc[i]--;
            if (svc[i] == 0) begin req[i] = 1'b0; lck[i] = 1'b0; end
          end
        end
      end
      if (cpu_gnt) begin
        if ($urandom % 16 == 0) cpu_lock = !cpu_lock;
      end else cpu_lock = 1'b0;
      urgent = ($urandom % 3 == 0);
      lat = int'($urandom % 4);
      p_own = {gnt, cpu_gnt}; p_req = req; p_gnt = gnt; p_cpu = cpu_gnt; p_hlda = hlda;
    end

    // drain: with no requests the processor must come back
    begin
      int n = 0;
      cpu_lock = 1'b0;
      while (!cpu_gnt && n < 60) begin
        for (int i = 0; i < N; i++) if (gnt[i]) begin req[i] = 1'b0; lck[i] = 1'b0; end
        if (!gnt) begin req = '0; lck = '0; end
        tick(); n++;
      end
      req = '0; lck = '0;
      repeat (2) tick();
      chk("R9 drain cpu back", 32'(cpu_gnt), 1);
    end
    summary();
  end
endmodule